// File: doc/BRIEF.md
# Eight-Pin GPIO Controller with Edge-Triggered Interrupt

This block gives software control over eight general-purpose pins through a small register window on a plain 32-bit bus strobe (valid, write, address, write data, read data). Each pin has a direction bit. The output level is changed only through a write-one-to-set register and a write-one-to-clear register, so one write can move any group of pins without a read-modify-write. The synchronised level of every pin can be read at any time, whatever the pin's direction.

Each pin can record rising transitions, falling transitions or both in a pending-event register. Software clears that register by writing ones. A separate enable mask selects which pending bits drive the single combined interrupt line. The bus has no back-pressure. A write takes effect at the clock edge on which `bus_valid` and `bus_write` are high. Read data is combinational and is valid while `bus_valid` is high and `bus_write` is low. It is zero at all other times.

Top module: `pin_io_ctrl`

## Requirements
- R1: After reset, direction, output latch, both edge enables, interrupt enable and pending register are all zero, so `pin_oe`, `pin_out` and `irq` are low.
- R2: A write to offset 0x034 sets every output latch bit whose data bit is 1 and leaves the other bits unchanged. A read of offset 0x034 or 0x04C returns the output latch.
- R3: A write to offset 0x04C clears every output latch bit whose data bit is 1 and leaves the other bits unchanged.
- R4: Offset 0x01C holds the direction, with 1 meaning output. For each pin i, `pin_oe[i]` equals direction bit i and `pin_out[i]` equals output latch bit i.
- R5: A read of offset 0x004 returns pin levels after a two-flop synchroniser, for both inputs and outputs. A pin change is visible after the second rising clock edge and not after the first.
- R6: When bit i of the rising-enable register (offset 0x064) is set, a low-to-high change of pin i sets pending bit i on the third clock edge after the change. Pins whose bit is clear do not record the change.
- R7: When bit i of the falling-enable register (offset 0x07C) is set, a high-to-low change of pin i sets pending bit i in the same way.
- R8: Writing the pending register (offset 0x0C4) clears each bit written as 1. Bits written as 0 keep their value.
- R9: `irq` is high exactly when some bit is set in both the pending register and the interrupt-enable register (offset 0x0AC). Pending bits of disabled pins still latch.
- R10: If an edge is detected on a pin in the same cycle as a clear write to its pending bit, the bit stays set.
- R11: A read of any offset other than those listed returns zero, and a write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data; bit i is pin i |
| bus_rdata | output | 32 | Read data; zero when no read is active |
| pin_in | input | 8 | Raw pad levels, asynchronous |
| pin_oe | output | 8 | Pad drive enable per pin |
| pin_out | output | 8 | Pad drive value per pin |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume bus inputs are stable around the rising clock edge and that `pin_in` holds each new value for several cycles, so the synchroniser sees every change as one clean edge. The bench changes pins and bus signals only on falling edges. It holds every pin value for at least three edges before looking at the result, and it never issues a set and a clear in the same cycle, because the bus allows one access per cycle.

// File: rtl/pin_io_pkg.sv
package pin_io_pkg;
  localparam int unsigned OFF_LEVEL = 32'h004;
  localparam int unsigned OFF_DIR   = 32'h01C;
  localparam int unsigned OFF_SET   = 32'h034;
  localparam int unsigned OFF_CLR   = 32'h04C;
  localparam int unsigned OFF_RISE  = 32'h064;
  localparam int unsigned OFF_FALL  = 32'h07C;
  localparam int unsigned OFF_IEN   = 32'h0AC;
  localparam int unsigned OFF_PEND  = 32'h0C4;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] synced
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= '0;
    else        chain_q[0] <= raw;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  assign synced = chain_q[STAGES-1];
endmodule

// File: rtl/pin_edge_unit.sv
module pin_edge_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] pend
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise_hit, fall_hit, edge_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  assign rise_hit = rise_en & level & ~prev_q;
  assign fall_hit = fall_en & ~level & prev_q;
  assign edge_hit = rise_hit | fall_hit;

  // a fresh edge takes precedence over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_mask) | edge_hit;
  end

  // R6
  rise_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_hit != '0) |=> ((pend & $past(rise_hit)) == $past(rise_hit)));

  // R7
  fall_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_hit != '0) |=> ((pend & $past(fall_hit)) == $past(fall_hit)));

  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_mask & ~edge_hit) != '0) |=> ((pend & $past(clr_mask & ~edge_hit)) == '0));

  // R10
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_mask & edge_hit) != '0) |=> ((pend & $past(clr_mask & edge_hit)) != '0));
endmodule

// File: rtl/pin_regs.sv
module pin_regs
  import pin_io_pkg::*;
#(
  parameter int W      = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      wd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [W-1:0]      level,
  input  logic [W-1:0]      pend,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      out_q,
  output logic [W-1:0]      rise_q,
  output logic [W-1:0]      fall_q,
  output logic [W-1:0]      ien_q,
  output logic [W-1:0]      clr_mask
);
  logic wr, rd;
  logic hit_level, hit_dir, hit_set, hit_clr, hit_rise, hit_fall, hit_ien, hit_pend;
  logic mapped;
  logic [W-1:0] rd_sel;

  assign wr = bus_valid & bus_write;
  assign rd = bus_valid & ~bus_write;

  assign hit_level = (bus_addr == ADDR_W'(OFF_LEVEL));
  assign hit_dir   = (bus_addr == ADDR_W'(OFF_DIR));
  assign hit_set   = (bus_addr == ADDR_W'(OFF_SET));
  assign hit_clr   = (bus_addr == ADDR_W'(OFF_CLR));
  assign hit_rise  = (bus_addr == ADDR_W'(OFF_RISE));
  assign hit_fall  = (bus_addr == ADDR_W'(OFF_FALL));
  assign hit_ien   = (bus_addr == ADDR_W'(OFF_IEN));
  assign hit_pend  = (bus_addr == ADDR_W'(OFF_PEND));
  assign mapped = hit_level | hit_dir | hit_set | hit_clr | hit_rise |
                  hit_fall | hit_ien | hit_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      ien_q  <= '0;
    end else if (wr) begin
      if (hit_dir)  dir_q  <= wd;
      if (hit_set)  out_q  <= out_q | wd;
      if (hit_clr)  out_q  <= out_q & ~wd;
      if (hit_rise) rise_q <= wd;
      if (hit_fall) fall_q <= wd;
      if (hit_ien)  ien_q  <= wd;
    end
  end

  assign clr_mask = (wr && hit_pend) ? wd : '0;

  always_comb begin
    rd_sel = '0;
    if (rd) begin
      unique case (1'b1)
        hit_level:         rd_sel = level;
        hit_dir:           rd_sel = dir_q;
        hit_set, hit_clr:  rd_sel = out_q;
        hit_rise:          rd_sel = rise_q;
        hit_fall:          rd_sel = fall_q;
        hit_ien:           rd_sel = ien_q;
        hit_pend:          rd_sel = pend;
        default:           rd_sel = '0;
      endcase
    end
  end

  assign bus_rdata = DATA_W'(rd_sel);

  // R2
  set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_set) |=> ((out_q & $past(wd)) == $past(wd)));

  // R3
  clr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_clr) |=> ((out_q & $past(wd)) == '0));

  // R11
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !mapped) |=> ($stable(dir_q) && $stable(out_q) && $stable(rise_q) &&
                         $stable(fall_q) && $stable(ien_q)));

  // R11
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !mapped) |-> (bus_rdata == '0));
endmodule

// File: rtl/pin_io_ctrl.sv
module pin_io_ctrl #(
  parameter int NUM_PINS    = 8,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_out,
  output logic              irq
);
  logic [NUM_PINS-1:0] level, pend, dir_q, out_q, rise_q, fall_q, ien_q, clr_mask;
  logic                unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_PINS];

  pin_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .synced(level)
  );

  pin_edge_unit #(.W(NUM_PINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .level(level), .rise_en(rise_q),
    .fall_en(fall_q), .clr_mask(clr_mask), .pend(pend)
  );

  pin_regs #(.W(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .wd(bus_wdata[NUM_PINS-1:0]), .bus_rdata(bus_rdata),
    .level(level), .pend(pend), .dir_q(dir_q), .out_q(out_q),
    .rise_q(rise_q), .fall_q(fall_q), .ien_q(ien_q), .clr_mask(clr_mask)
  );

  assign pin_oe  = dir_q;
  assign pin_out = out_q;
  assign irq     = |(pend & ien_q);

  // R9
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

  // R9
  irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend != '0));
endmodule

// File: tb/pin_io_ctrl_bench.sv
module pin_io_ctrl_bench;
  localparam int NP = 8;
  localparam logic [11:0] A_LEVEL = 12'h004, A_DIR = 12'h01C, A_SET = 12'h034,
    A_CLR = 12'h04C, A_RISE = 12'h064, A_FALL = 12'h07C, A_IEN = 12'h0AC, A_PEND = 12'h0C4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_oe, pin_out;
  logic irq;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pin_io_ctrl u_pin_io_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic settle(input logic [NP-1:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(posedge clk);
    wr(A_PEND, 32'hFF);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    @(negedge clk);
    rd(A_DIR, d);  check("R1 dir", d, 0);
    rd(A_SET, d);  check("R1 out", d, 0);
    rd(A_RISE, d); check("R1 rise", d, 0);
    rd(A_FALL, d); check("R1 fall", d, 0);
    rd(A_IEN, d);  check("R1 ien", d, 0);
    rd(A_PEND, d); check("R1 pend", d, 0);
    check("R1 pins", {pin_oe, pin_out, 7'd0, irq}, 0);
  endtask

  task automatic t_outputs;
    logic [31:0] d;
    wr(A_DIR, 32'hF0);
    check("R4 oe", pin_oe, 8'hF0);
    wr(A_SET, 32'h0F);
    check("R2 set", pin_out, 8'h0F);
    wr(A_SET, 32'h30);
    check("R2 zeros keep", pin_out, 8'h3F);
    wr(A_CLR, 32'h05);
    check("R3 clear", pin_out, 8'h3A);
    @(negedge clk);
    rd(A_CLR, d); check("R2 read clr off", d, 32'h3A);
    rd(A_SET, d); check("R2 read set off", d, 32'h3A);
  endtask

  task automatic t_level;
    logic [31:0] d;
    @(negedge clk);
    pin_in = 8'hA5;
    @(posedge clk); @(negedge clk);
    rd(A_LEVEL, d); check("R5 one edge", d, 0);
    @(posedge clk); @(negedge clk);
    rd(A_LEVEL, d); check("R5 two edges", d, 32'hA5);
  endtask

  task automatic t_rising;
    logic [31:0] d;
    wr(A_RISE, 32'h01); wr(A_FALL, 0); wr(A_IEN, 0);
    settle(8'h00);
    @(negedge clk); pin_in = 8'h03;
    repeat (2) @(posedge clk); @(negedge clk);
    rd(A_PEND, d); check("R6 not yet", d, 0);
    @(posedge clk); @(negedge clk);
    rd(A_PEND, d); check("R6 rise latched", d, 32'h01);
    check("R9 disabled no irq", irq, 0);
    wr(A_IEN, 32'h01);
    check("R9 irq", irq, 1);
  endtask

  task automatic t_falling;
    logic [31:0] d;
    wr(A_RISE, 0); wr(A_FALL, 32'h80); wr(A_IEN, 32'h80);
    settle(8'h00);
    @(negedge clk); pin_in = 8'h80;
    repeat (3) @(posedge clk); @(negedge clk);
    rd(A_PEND, d); check("R6 rise not enabled", d, 0);
    pin_in = 8'h00;
    repeat (3) @(posedge clk); @(negedge clk);
    rd(A_PEND, d); check("R7 fall latched", d, 32'h80);
    check("R9 irq fall", irq, 1);
    wr(A_PEND, 32'h00);
    @(negedge clk); rd(A_PEND, d); check("R8 zero write keeps", d, 32'h80);
    wr(A_PEND, 32'h80);
    @(negedge clk); rd(A_PEND, d); check("R8 one write clears", d, 0);
    check("R9 irq drops", irq, 0);
  endtask

  task automatic t_edge_wins;
    logic [31:0] d;
    wr(A_RISE, 32'h01); wr(A_FALL, 0);
    settle(8'h00);
    @(negedge clk); pin_in = 8'h01;
    repeat (3) @(posedge clk);
    @(negedge clk); pin_in = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk); rd(A_PEND, d); check("R10 pre set", d, 32'h01);
    pin_in = 8'h01;
    repeat (2) @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = A_PEND; bus_wdata = 32'h01;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    rd(A_PEND, d); check("R10 edge wins", d, 32'h01);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    @(negedge clk);
    rd(12'h008, d); check("R11 read 008", d, 0);
    rd(12'h0FC, d); check("R11 read 0FC", d, 0);
    wr(12'h020, 32'hFF);
    wr(12'h038, 32'hFF);
    check("R11 oe kept", pin_oe, 8'hF0);
    check("R11 out kept", pin_out, 8'h3A);
    @(negedge clk);
    rd(A_RISE, d); check("R11 rise kept", d, 32'h01);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_outputs();
    t_level();
    t_rising();
    t_falling();
    t_edge_wins();
    t_unmapped();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule